// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers event pulses from nearby logic into a sticky status register. Each bit of that register can be hidden by a matching mask bit. A single active-high interrupt line is raised whenever at least one status bit is pending and not masked. Software reaches the block through a byte-wide register port with a combinational read path. The port exposes both byte halves of the mask, both byte halves of the status, and two write-one-to-clear acknowledge locations, one for each status byte.

Four named sources feed fixed status bits: a periodic timer tick, an alarm match, an update error and a push-button. The button comes in as a raw level. It passes through a two-flop synchronizer, and only a low-to-high transition records an event. Eight spare set inputs drive the low status byte. In this build twelve status bits exist, and the upper four bits of the 16-bit status view always read as zero.

Top module: `irq_status_agg`

## Requirements
- R1: `irqOut` is high exactly when some bit of (status AND NOT mask) is set. It follows any mask write, acknowledge write or set pulse at the clock edge that captures that operation.
- R2: After reset the mask reads 0x0FFF (0xFF at the low byte, 0x0F at the high byte), the status reads 0, and `irqOut` is low.
- R3: A write to offset 0x00 replaces mask bits 7:0 and keeps bits 15:8. A write to offset 0x01 replaces mask bits 15:8 and keeps bits 7:0.
- R4: A write to offset 0x04 clears each status bit 7:0 whose position holds a one in the written byte. A write to offset 0x05 does the same for status bits 15:8. Status bits at zero positions of the written byte are left unchanged. Both offsets read back as 0.
- R5: Reads return mask bits 7:0 at 0x00, mask bits 15:8 at 0x01, status bits 7:0 at 0x02 and status bits 15:8 at 0x03. Any other offset reads 0, and writes to any other offset change nothing.
- R6: A one-cycle set pulse makes its status bit 1 at the next clock edge, and the bit stays set until it is acknowledged. The bit positions are: `tickSet` bit 8, `alarmSet` bit 9, `updErrSet` bit 10, push-button bit 11, and `spareSet[i]` bit i.
- R7: Status bit 11 is set only by a low-to-high change of `buttonIn`. It becomes visible after the third rising clock edge that follows the change. While the input stays high, the bit is not set again after an acknowledge.
- R8: When a set pulse and an acknowledge hit the same bit in one cycle, the bit ends up set.
- R9: Status bits 15:12 have no source and always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Register offset for the read and write |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 8 | Write data byte |
| busRdData | output | 8 | Combinational read data for `busAddr` |
| tickSet | input | 1 | Periodic timer tick pulse |
| alarmSet | input | 1 | Alarm match pulse |
| updErrSet | input | 1 | Update error pulse |
| buttonIn | input | 1 | Raw push-button level, asynchronous |
| spareSet | input | 8 | Set pulses for status bits 7:0 |
| irqOut | output | 1 | Active-high interrupt request |

## Verification
Several patterns drive the aggregation. A pending tick under the reset mask shows that masking suppresses the line. The mask is then opened one byte at a time, which separates the low and high mask halves and shows that the high half is kept when the low half is written. Spare-bit patterns such as 0xA5, acknowledged with partial bytes, tell a bitwise clear apart from a whole-byte clear. A set and an acknowledge on the same bit in one cycle show which of the two wins. A button held high across an acknowledge separates edge detection from level detection. A reference model checks the read port and the interrupt line on every cycle.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

  localparam int BYTE_W = 8;
  localparam int REG_W  = 2 * BYTE_W;

  // register offsets relative to the block base
  localparam int OFF_MASK_LO = 0;
  localparam int OFF_MASK_HI = 1;
  localparam int OFF_STAT_LO = 2;
  localparam int OFF_STAT_HI = 3;
  localparam int OFF_ACK_LO  = 4;
  localparam int OFF_ACK_HI  = 5;

  typedef enum logic [2:0] {
    RD_ZERO    = 3'd0,
    RD_MASK_LO = 3'd1,
    RD_MASK_HI = 3'd2,
    RD_STAT_LO = 3'd3,
    RD_STAT_HI = 3'd4
  } rdSel_t;

  typedef struct packed {
    logic   maskLoWr;
    logic   maskHiWr;
    logic   ackLoWr;
    logic   ackHiWr;
    rdSel_t rdSel;
  } regStrobe_t;

endpackage

// File: rtl/irqs_ctrl.sv
module irqs_ctrl
  import irqs_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output regStrobe_t        stb
);

  localparam logic [ADDR_W-1:0] A_MASK_LO = ADDR_W'(BASE_ADDR + OFF_MASK_LO);
  localparam logic [ADDR_W-1:0] A_MASK_HI = ADDR_W'(BASE_ADDR + OFF_MASK_HI);
  localparam logic [ADDR_W-1:0] A_STAT_LO = ADDR_W'(BASE_ADDR + OFF_STAT_LO);
  localparam logic [ADDR_W-1:0] A_STAT_HI = ADDR_W'(BASE_ADDR + OFF_STAT_HI);
  localparam logic [ADDR_W-1:0] A_ACK_LO  = ADDR_W'(BASE_ADDR + OFF_ACK_LO);
  localparam logic [ADDR_W-1:0] A_ACK_HI  = ADDR_W'(BASE_ADDR + OFF_ACK_HI);

  always_comb begin
    stb.maskLoWr = busWrEn && (busAddr == A_MASK_LO);
    stb.maskHiWr = busWrEn && (busAddr == A_MASK_HI);
    stb.ackLoWr  = busWrEn && (busAddr == A_ACK_LO);
    stb.ackHiWr  = busWrEn && (busAddr == A_ACK_HI);
    if (busAddr == A_MASK_LO)      stb.rdSel = RD_MASK_LO;
    else if (busAddr == A_MASK_HI) stb.rdSel = RD_MASK_HI;
    else if (busAddr == A_STAT_LO) stb.rdSel = RD_STAT_LO;
    else if (busAddr == A_STAT_HI) stb.rdSel = RD_STAT_HI;
    else                           stb.rdSel = RD_ZERO;
  end

  // R5: at most one register is written per access
  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.maskLoWr, stb.maskHiWr, stb.ackLoWr, stb.ackHiWr}));

endmodule

// File: rtl/irqs_edge.sv
module irqs_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic riseOut
);

  logic [STAGES-1:0] syncQ;
  logic              prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[STAGES-2:0], rawIn};
      prevQ <= syncQ[STAGES-1];
    end
  end

  assign riseOut = syncQ[STAGES-1] & ~prevQ;

  // R7: a rising edge yields a single-cycle event
  p_rise_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    riseOut |=> !riseOut);

endmodule

// File: rtl/irqs_dpath.sv
module irqs_dpath
  import irqs_pkg::*;
#(
  parameter int NUM_SRC = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         stb,
  input  logic [BYTE_W-1:0]  busWrData,
  input  logic [NUM_SRC-1:0] setVec,
  output logic [BYTE_W-1:0]  busRdData,
  output logic               irqOut
);

  localparam logic [REG_W-1:0] MASK_RST =
    REG_W'({NUM_SRC{1'b1}});

  logic [NUM_SRC-1:0] statusQ;
  logic [REG_W-1:0]   maskQ;
  logic [REG_W-1:0]   ackVec;
  logic [REG_W-1:0]   statusWide;
  logic [REG_W-1:0]   setWide;

  generate
    if (NUM_SRC < REG_W) begin : g_pad
      assign statusWide = {{(REG_W-NUM_SRC){1'b0}}, statusQ};
      assign setWide    = {{(REG_W-NUM_SRC){1'b0}}, setVec};
    end else begin : g_full
      assign statusWide = statusQ;
      assign setWide    = setVec;
    end
  endgenerate

  always_comb begin
    ackVec = '0;
    if (stb.ackLoWr) ackVec[BYTE_W-1:0]     = busWrData;
    if (stb.ackHiWr) ackVec[REG_W-1:BYTE_W] = busWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
    end else begin
      statusQ <= (statusQ & ~ackVec[NUM_SRC-1:0]) | setVec;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= MASK_RST;
    end else begin
      if (stb.maskLoWr) maskQ[BYTE_W-1:0]     <= busWrData;
      if (stb.maskHiWr) maskQ[REG_W-1:BYTE_W] <= busWrData;
    end
  end

  assign irqOut = |(statusWide & ~maskQ);

  always_comb begin
    case (stb.rdSel)
      RD_MASK_LO: busRdData = maskQ[BYTE_W-1:0];
      RD_MASK_HI: busRdData = maskQ[REG_W-1:BYTE_W];
      RD_STAT_LO: busRdData = statusWide[BYTE_W-1:0];
      RD_STAT_HI: busRdData = statusWide[REG_W-1:BYTE_W];
      default:    busRdData = '0;
    endcase
  end

  // R1: the line is never raised without a pending bit
  p_irq_pending_r1: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (statusWide != '0));

  // R3: a low-half mask write leaves the high half alone
  p_mask_lo_keep_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.maskLoWr && !stb.maskHiWr) |=> (maskQ[REG_W-1:BYTE_W] == $past(maskQ[REG_W-1:BYTE_W])));

  // R3: a high-half mask write leaves the low half alone
  p_mask_hi_keep_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.maskHiWr && !stb.maskLoWr) |=> (maskQ[BYTE_W-1:0] == $past(maskQ[BYTE_W-1:0])));

  // R4: low acknowledge clears the selected bits when nothing sets them
  p_ack_lo_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ackLoWr && setWide[BYTE_W-1:0] == '0) |=>
      ((statusWide[BYTE_W-1:0] & $past(busWrData)) == '0));

  // R4: high acknowledge clears the selected bits when nothing sets them
  p_ack_hi_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ackHiWr && setWide[REG_W-1:BYTE_W] == '0) |=>
      ((statusWide[REG_W-1:BYTE_W] & $past(busWrData)) == '0));

  // R6: without an acknowledge, pending bits stay pending
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.ackLoWr || stb.ackHiWr) |=> ((statusWide & $past(statusWide)) == $past(statusWide)));

  // R8: every pulsed bit is set afterwards, acknowledge or not
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (setWide != '0) |=> ((statusWide & $past(setWide)) == $past(setWide)));

endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irqs_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int BASE_ADDR   = 0,
  parameter int NUM_SPARE   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [BYTE_W-1:0]    busWrData,
  output logic [BYTE_W-1:0]    busRdData,
  input  logic                 tickSet,
  input  logic                 alarmSet,
  input  logic                 updErrSet,
  input  logic                 buttonIn,
  input  logic [NUM_SPARE-1:0] spareSet,
  output logic                 irqOut
);

  localparam int NUM_SRC = NUM_SPARE + 4;

  regStrobe_t         stb;
  logic               btnRise;
  logic [NUM_SRC-1:0] setVec;

  // order fixes the bit positions: spare, tick, alarm, error, button
  assign setVec = {btnRise, updErrSet, alarmSet, tickSet, spareSet};

  irqs_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .stb     (stb)
  );

  irqs_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   (buttonIn),
    .riseOut (btnRise)
  );

  irqs_dpath #(.NUM_SRC(NUM_SRC)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busWrData (busWrData),
    .setVec    (setVec),
    .busRdData (busRdData),
    .irqOut    (irqOut)
  );

endmodule

// File: tb/irq_status_agg_test.sv
`timescale 1ns/1ps
module irq_status_agg_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic       tickSet = 1'b0, alarmSet = 1'b0, updErrSet = 1'b0, buttonIn = 1'b0;
  logic [7:0] spareSet = 8'h00;
  logic       irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  irq_status_agg uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .tickSet(tickSet),
    .alarmSet(alarmSet), .updErrSet(updErrSet), .buttonIn(buttonIn),
    .spareSet(spareSet), .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: integers and a history queue for the button
  int mStatus, mMask;
  bit btnHist[$];

  always @(posedge clk) begin
    int setBits, clrBits;
    bit rise;
    if (!rstN) begin
      mStatus = 0;
      mMask   = 'h0FFF;
      btnHist = {1'b0, 1'b0, 1'b0};
    end else begin
      // button seen two edges ago versus three edges ago
      rise = btnHist[1] && !btnHist[2];
      btnHist.push_front(buttonIn);
      void'(btnHist.pop_back());
      setBits = spareSet | (tickSet << 8) | (alarmSet << 9) | (updErrSet << 10) | (rise << 11);
      clrBits = 0;
      if (busWrEn && busAddr == 8'h04) clrBits = busWrData;
      if (busWrEn && busAddr == 8'h05) clrBits = busWrData << 8;
      mStatus = ((mStatus & ~clrBits) | setBits) & 'h0FFF;
      if (busWrEn && busAddr == 8'h00) mMask = (mMask & 'hFF00) | busWrData;
      if (busWrEn && busAddr == 8'h01) mMask = (mMask & 'h00FF) | (busWrData << 8);
    end
    #2;
    if (rstN && !done) begin
      int expRd;
      case (busAddr)
        8'h00: expRd = mMask & 'hFF;
        8'h01: expRd = (mMask >> 8) & 'hFF;
        8'h02: expRd = mStatus & 'hFF;
        8'h03: expRd = (mStatus >> 8) & 'hFF;
        default: expRd = 0;
      endcase
      check(irqOut == ((mStatus & ~mMask) != 0), "R1 model irq", irqOut, (mStatus & ~mMask) != 0);
      check(busRdData == expRd[7:0], "R5 model read", busRdData, expRd);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [7:0] a, input int exp, input string tag);
    @(negedge clk);
    busAddr = a;
    @(posedge clk);
    #1;
    check(busRdData == exp[7:0], tag, busRdData, exp);
  endtask

  task automatic irqChk(input bit exp, input string tag);
    @(posedge clk);
    #1;
    check(irqOut == exp, tag, irqOut, exp);
  endtask

  task automatic pulse(input logic [7:0] sp, input bit t, input bit al, input bit er);
    @(negedge clk);
    spareSet = sp; tickSet = t; alarmSet = al; updErrSet = er;
    @(negedge clk);
    spareSet = 8'h00; tickSet = 1'b0; alarmSet = 1'b0; updErrSet = 1'b0;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2 reset state
    rdChk(8'h00, 'hFF, "R2 mask low after reset");
    rdChk(8'h01, 'h0F, "R2 mask high after reset");
    rdChk(8'h02, 'h00, "R2 status low after reset");
    rdChk(8'h03, 'h00, "R2 status high after reset");
    irqChk(1'b0, "R2 irq low after reset");

    // R6 tick sets bit 8, masked so no irq (R1)
    pulse(8'h00, 1'b1, 1'b0, 1'b0);
    rdChk(8'h03, 'h01, "R6 tick on bit 8");
    irqChk(1'b0, "R1 masked tick no irq");

    // R3 mask halves
    wr(8'h00, 8'h00);
    rdChk(8'h01, 'h0F, "R3 high kept on low write");
    irqChk(1'b0, "R1 bit 8 still masked");
    wr(8'h01, 8'h0E);
    rdChk(8'h00, 'h00, "R3 low kept on high write");
    irqChk(1'b1, "R1 unmasked tick raises irq");

    // R4 acknowledges
    wr(8'h04, 8'h01);
    rdChk(8'h03, 'h01, "R4 low ack leaves high byte");
    wr(8'h05, 8'h01);
    rdChk(8'h03, 'h00, "R4 high ack clears bit 8");
    irqChk(1'b0, "R1 irq drops after ack");
    rdChk(8'h04, 'h00, "R4 ack low reads zero");
    rdChk(8'h05, 'h00, "R4 ack high reads zero");

    // R6 spare bits, R4 partial clear
    pulse(8'hA5, 1'b0, 1'b0, 1'b0);
    rdChk(8'h02, 'hA5, "R6 spare pattern");
    irqChk(1'b1, "R1 spare unmasked irq");
    wr(8'h04, 8'h05);
    rdChk(8'h02, 'hA0, "R4 bitwise clear");

    // R8 set and ack on same bit
    @(negedge clk);
    busAddr = 8'h04; busWrData = 8'h20; busWrEn = 1'b1; spareSet = 8'h20;
    @(negedge clk);
    busWrEn = 1'b0; spareSet = 8'h00;
    rdChk(8'h02, 'hA0, "R8 set wins over ack");
    wr(8'h04, 8'hFF);
    rdChk(8'h02, 'h00, "R4 full low clear");

    // R7 button latency and edge behaviour
    @(negedge clk);
    busAddr = 8'h03;
    buttonIn = 1'b1;
    @(posedge clk); #1;
    check(busRdData == 8'h00, "R7 not set after edge 1", busRdData, 0);
    @(posedge clk); #1;
    check(busRdData == 8'h00, "R7 not set after edge 2", busRdData, 0);
    @(posedge clk); #1;
    check(busRdData == 8'h08, "R7 set after edge 3", busRdData, 8);
    wr(8'h05, 8'h08);
    repeat (10) @(negedge clk);
    rdChk(8'h03, 'h00, "R7 held level does not re-set");
    @(negedge clk); buttonIn = 1'b0;
    repeat (4) @(negedge clk);
    rdChk(8'h03, 'h00, "R7 falling edge ignored");
    @(negedge clk); buttonIn = 1'b1;
    repeat (4) @(negedge clk);
    rdChk(8'h03, 'h08, "R7 second rise sets");

    // R6 alarm and error, R9 upper nibble zero
    pulse(8'h00, 1'b1, 1'b1, 1'b1);
    rdChk(8'h03, 'h0F, "R6 R9 all high sources, upper zero");
    wr(8'h05, 8'hF0);
    rdChk(8'h03, 'h0F, "R9 upper ack no effect");
    wr(8'h05, 8'h09);
    rdChk(8'h03, 'h06, "R6 alarm bit 9 and error bit 10");

    // R1 full mask hides pending
    wr(8'h01, 8'hFF);
    irqChk(1'b0, "R1 full mask no irq");
    rdChk(8'h01, 'hFF, "R3 high byte written");

    // R5 unmapped offset
    wr(8'h07, 8'hFF);
    rdChk(8'h07, 'h00, "R5 unmapped reads zero");
    rdChk(8'h00, 'h00, "R5 unmapped write leaves mask");
    rdChk(8'h03, 'h06, "R5 unmapped write leaves status");

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule